// File: doc/BRIEF.md
# Page Program Buffer with In-Page Wrap

This block sits behind the serial front end of a flash-style memory and turns one page-program command into array updates. A start strobe brings in the target byte address. A stream of data bytes follows, each qualified by a valid strobe. A commit pulse then marks a command that ended cleanly. The bytes are gathered into a 128-byte page buffer. The write position comes from the low seven address bits and wraps inside the page. A per-offset mask records which bytes were actually supplied.

On commit, a self-timed program cycle begins and a busy flag rises. During the cycle a walker visits each marked offset of the addressed page in an external byte array. For each one it reads the old byte, then writes back the old byte ANDed with the buffered byte, so bits can only go from 1 to 0. The busy flag stays high for a fixed, parameterised number of clocks, whatever the number of bytes. A one-cycle done pulse marks the end. Serial shifting, opcode decode and protection checks happen upstream.

Top module: `pp_page_program`

## Requirements
- R1: After reset, `busy`, `done`, `arr_rd_en` and `arr_wr_en` are all low.
- R2: A `cmd_start` taken while idle sets the page from `cmd_addr[ADDR_W-1:7]` and the write offset from `cmd_addr[6:0]`, and clears the byte mask. Each following `din_valid` byte goes to the current offset, which then advances by one. Upstream raises at most one of `cmd_start`, `din_valid` and `cmd_commit` in any cycle.
- R3: The write offset advances modulo 128. Bytes that pass offset 127 continue at offset 0 of the same page.
- R4: When more than 128 bytes are sent, a later byte replaces an earlier one at the same offset, so only the final 128 bytes are programmed.
- R5: Array bytes whose offsets received no data, and all other pages, keep their previous values.
- R6: A programmed byte becomes its old array value AND the buffered byte. Every array write satisfies `(arr_wdata & ~arr_rdata) == 0`.
- R7: A `cmd_commit` is ignored (no busy, no array access) when no data byte arrived since the last accepted `cmd_start`. It is also ignored when there was no `cmd_start` since the previous commit. Data bytes in that state are ignored as well.
- R8: An accepted commit raises `busy` on the next clock. `busy` stays high for exactly `PROG_CYCLES` cycles. `done` is high for one cycle, the first cycle in which `busy` is low again.
- R9: While `busy` is high, `cmd_start`, `din_valid` and `cmd_commit` have no effect: the cycle length and the programmed data are unchanged, and nothing is armed afterwards.
- R10: The array is read or written only while `busy` is high, never both in one cycle. Each write goes to the address read in the previous cycle, and `arr_rdata` is valid one cycle after `arr_rd_en`.
- R11: A new `cmd_start` with no commit for the previous command discards the bytes gathered before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start of a program command; loads `cmd_addr` |
| cmd_addr | input | ADDR_W | Byte address of the first data byte |
| din_valid | input | 1 | One data byte present on `din` |
| din | input | 8 | Data byte |
| cmd_commit | input | 1 | Command ended on a byte boundary; request programming |
| arr_rd_en | output | 1 | Array read request at `arr_addr` |
| arr_wr_en | output | 1 | Array write request at `arr_addr` |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, one cycle after `arr_rd_en` |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle pulse at the end of a program cycle |

## Verification
The assertions assume upstream never raises two of the three command strobes in one cycle. They also assume the array returns read data exactly one cycle after a read request. The bench drives one strobe per cycle from a single task, and its array model answers reads on the next edge. The check that written data never sets a bit absent from the read data relies on the same array timing. `PROG_CYCLES` is taken to be at least twice the page size plus one, so that the walk finishes inside the busy window. The bench configuration meets this.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SCAN,
        PH_WRITE
    } walk_phase_e;

    // flash cells only discharge: a bit already at 0 stays 0
    function automatic logic [BYTE_W-1:0] and_program(
        input logic [BYTE_W-1:0] old_b,
        input logic [BYTE_W-1:0] new_b
    );
        return old_b & new_b;
    endfunction

endpackage

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic [ADDR_W-1:0]         load_addr,
    input  logic                      put,
    input  logic [pp_pkg::BYTE_W-1:0] put_data,
    input  logic [OFF_W-1:0]          rd_off,
    output logic [PAGE_W-1:0]         page_idx,
    output logic                      any_valid,
    output logic [pp_pkg::BYTE_W-1:0] rd_data,
    output logic                      rd_valid
);
    import pp_pkg::*;

    typedef struct packed {
        logic [PAGE_BYTES-1:0][BYTE_W-1:0] bytes;
        logic [PAGE_BYTES-1:0]             mask;
        logic [OFF_W-1:0]                  ptr;
        logic [PAGE_W-1:0]                 page;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.mask = '0;
            st_d.ptr  = load_addr[OFF_W-1:0];
            st_d.page = load_addr[ADDR_W-1:OFF_W];
        end else if (put) begin
            st_d.bytes[st_q.ptr] = put_data;
            st_d.mask[st_q.ptr]  = 1'b1;
            // natural overflow of the OFF_W-bit pointer gives the in-page wrap
            st_d.ptr             = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page_idx  = st_q.page;
    assign any_valid = |st_q.mask;
    assign rd_data   = st_q.bytes[rd_off];
    assign rd_valid  = st_q.mask[rd_off];

endmodule

// File: rtl/pp_cycle_timer.sv
module pp_cycle_timer #(
    parameter int PROG_CYCLES = 600,
    localparam int CNT_W      = $clog2(PROG_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (launch) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

endmodule

// File: rtl/pp_rmw_seq.sv
module pp_rmw_seq #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic [PAGE_W-1:0]         page_idx,
    input  logic [pp_pkg::BYTE_W-1:0] buf_data,
    input  logic                      buf_valid,
    input  logic [pp_pkg::BYTE_W-1:0] arr_rdata,
    output logic [OFF_W-1:0]          rd_off,
    output logic                      arr_rd_en,
    output logic                      arr_wr_en,
    output logic [ADDR_W-1:0]         arr_addr,
    output logic [pp_pkg::BYTE_W-1:0] arr_wdata
);
    import pp_pkg::*;

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    typedef struct packed {
        walk_phase_e      phase;
        logic [OFF_W-1:0] off;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        arr_rd_en = 1'b0;
        arr_wr_en = 1'b0;
        arr_wdata = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (launch) begin
                    st_d.phase = PH_SCAN;
                    st_d.off   = '0;
                end
            end
            PH_SCAN: begin
                if (buf_valid) begin
                    arr_rd_en  = 1'b1;
                    st_d.phase = PH_WRITE;
                end else if (st_q.off == LAST_OFF) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.off = st_q.off + 1'b1;
                end
            end
            PH_WRITE: begin
                arr_wr_en = 1'b1;
                arr_wdata = and_program(arr_rdata, buf_data);
                if (st_q.off == LAST_OFF) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.phase = PH_SCAN;
                    st_d.off   = st_q.off + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, off: '0};
        else        st_q <= st_d;
    end

    assign rd_off   = st_q.off;
    assign arr_addr = {page_idx, st_q.off};

endmodule

// File: rtl/pp_page_program.sv
module pp_page_program #(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BYTES  = 128,
    parameter int PROG_CYCLES = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              din_valid,
    input  logic [7:0]        din,
    input  logic              cmd_commit,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata,
    output logic              busy,
    output logic              done
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic armed;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic              take_start;
    logic              take_byte;
    logic              launch;
    logic              any_valid;
    logic [PAGE_W-1:0] page_idx;
    logic [OFF_W-1:0]  walk_off;
    logic [7:0]        buf_byte;
    logic              buf_valid;

    always_comb begin
        take_start = cmd_start & ~busy;
        take_byte  = din_valid & ~busy & ctl_q.armed & ~cmd_start;
        launch     = cmd_commit & ~busy & ctl_q.armed & any_valid
                     & ~cmd_start & ~din_valid;
        ctl_d = ctl_q;
        if (take_start) begin
            ctl_d.armed = 1'b1;
        end else if (cmd_commit & ~busy & ~din_valid) begin
            // any commit closes the command, whether it launches or not
            ctl_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pp_page_buf #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take_start),
        .load_addr (cmd_addr),
        .put       (take_byte),
        .put_data  (din),
        .rd_off    (walk_off),
        .page_idx  (page_idx),
        .any_valid (any_valid),
        .rd_data   (buf_byte),
        .rd_valid  (buf_valid)
    );

    pp_cycle_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy),
        .done   (done)
    );

    pp_rmw_seq #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .page_idx  (page_idx),
        .buf_data  (buf_byte),
        .buf_valid (buf_valid),
        .arr_rdata (arr_rdata),
        .rd_off    (walk_off),
        .arr_rd_en (arr_rd_en),
        .arr_wr_en (arr_wr_en),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

endmodule

// File: rtl/pp_page_program_chk.sv
module pp_page_program_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              din_valid,
    input logic              cmd_commit,
    input logic              arr_rd_en,
    input logic              arr_wr_en,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        arr_wdata,
    input logic [7:0]        arr_rdata,
    input logic              busy,
    input logic              done
);
    // R2: input rule, one command strobe per cycle
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start, din_valid, cmd_commit}));

    a_r10_access_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en || arr_wr_en) |-> busy);

    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_en && arr_wr_en));

    a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> ($past(arr_rd_en) && arr_addr == $past(arr_addr)));

    a_r6_and_only: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> ((arr_wdata & ~arr_rdata) == 8'h00));

    a_r8_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_commit));

    a_r8_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind pp_page_program pp_page_program_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .din_valid  (din_valid),
    .cmd_commit (cmd_commit),
    .arr_rd_en  (arr_rd_en),
    .arr_wr_en  (arr_wr_en),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata),
    .arr_rdata  (arr_rdata),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_pp_page_program.sv
module test_pp_page_program;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 9;
    localparam int PB         = 128;
    localparam int PC         = 270;
    localparam int MEM_N      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          din_valid = 1'b0;
    logic [7:0]    din = '0;
    logic          cmd_commit = 1'b0;
    logic          arr_rd_en, arr_wr_en;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;
    logic [7:0]    arr_rdata = '0;
    logic          busy, done;

    logic [7:0] mem     [MEM_N];
    logic [7:0] ref_mem [MEM_N];

    int  n_checks = 0;
    int  n_fail   = 0;
    int  bad_access = 0;
    int  bad_order  = 0;
    bit  prev_rd = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_page_program #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) i_pp_page_program (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .din_valid(din_valid), .din(din), .cmd_commit(cmd_commit),
        .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .busy(busy), .done(done)
    );

    // byte array model: one-cycle read latency
    always @(posedge clk) begin
        if ((arr_rd_en || arr_wr_en) && !busy) bad_access++;
        if (arr_wr_en && !(prev_rd && prev_addr == arr_addr)) bad_order++;
        prev_rd   = arr_rd_en;
        prev_addr = arr_addr;
        if (arr_rd_en) arr_rdata <= mem[arr_addr];
        if (arr_wr_en) mem[arr_addr] <= arr_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic logic [7:0] gen(input int seed, input int i);
        return 8'((seed * 13 + i * 29 + (i >> 3)) ^ (seed >> 2));
    endfunction

    // send one command; the reference is updated only if it should program
    task automatic send_cmd(input int addr, input int n, input int seed, input bit commit);
        logic [7:0] sb [PB];
        bit         sv [PB];
        int         ptr;
        int         pg;
        for (int i = 0; i < PB; i++) begin sb[i] = 8'h00; sv[i] = 1'b0; end
        ptr = addr % PB;
        pg  = (addr / PB) % (MEM_N / PB);
        @(negedge clk); cmd_start = 1'b1; cmd_addr = AW'(addr);
        @(negedge clk); cmd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            din_valid = 1'b1; din = gen(seed, i);
            sb[ptr] = gen(seed, i); sv[ptr] = 1'b1; ptr = (ptr + 1) % PB;
            @(negedge clk);
        end
        din_valid = 1'b0;
        if (commit) begin
            cmd_commit = 1'b1;
            @(negedge clk); cmd_commit = 1'b0;
            if (n > 0)
                for (int i = 0; i < PB; i++)
                    if (sv[i]) ref_mem[pg * PB + i] = ref_mem[pg * PB + i] & sb[i];
        end
    endtask

    // called at the negedge right after a commit was captured
    task automatic wait_program(input string req);
        int cnt = 0;
        while (busy && cnt < PC + 10) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == PC, "R8", {req, " busy length"}, cnt, PC);
        check(done == 1'b1, "R8", {req, " done at busy fall"}, int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R8", {req, " done one cycle"}, int'(done), 0);
    endtask

    task automatic compare_mem(input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MEM_N; i++)
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (bad != 0)
            check(1'b0, req, {what, " byte at first mismatch"}, int'(mem[first]),
                  int'(ref_mem[first]));
        else
            check(1'b1, req, what, 0, 0);
    endtask

    task automatic expect_idle(input string req, input string what);
        int seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (busy || arr_rd_en || arr_wr_en) seen++;
        end
        check(seen == 0, req, what, seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) begin mem[i] = 8'hFF; ref_mem[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && done == 0, "R1", "busy/done in reset", int'({busy, done}), 0);
        check(arr_rd_en == 0 && arr_wr_en == 0, "R1", "array strobes in reset",
              int'({arr_rd_en, arr_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0, "R1", "idle after reset", int'({busy, done}), 0);

        // R2: aligned full page
        send_cmd(1 * PB, PB, 1, 1'b1);
        wait_program("R2 full page");
        compare_mem("R2", "full aligned page");

        // R3: wrap from offset 120
        send_cmd(2 * PB + 120, 16, 2, 1'b1);
        wait_program("R3 wrap");
        compare_mem("R3", "wrap inside page");

        // R4: 200 bytes, only last 128 kept
        send_cmd(3 * PB + 5, 200, 3, 1'b1);
        wait_program("R4 overrun");
        compare_mem("R4", "last 128 bytes kept");

        // R5: few bytes only touch their offsets
        send_cmd(0 * PB + 10, 3, 4, 1'b1);
        wait_program("R5 short");
        compare_mem("R5", "untouched bytes");

        // R6: reprogram an already programmed page, result is AND
        send_cmd(1 * PB, 40, 5, 1'b1);
        wait_program("R6 and");
        check(mem[PB + 7] == (gen(1, 7) & gen(5, 7)), "R6", "AND of two programs",
              int'(mem[PB + 7]), int'(gen(1, 7) & gen(5, 7)));
        compare_mem("R6", "and-only page");

        // R7: commit with no data
        send_cmd(2 * PB, 0, 6, 1'b1);
        expect_idle("R7", "commit without data");
        // R7: bytes and commit with no start since last commit
        @(negedge clk); din_valid = 1'b1; din = 8'h00;
        @(negedge clk); din_valid = 1'b0; cmd_commit = 1'b1;
        @(negedge clk); cmd_commit = 1'b0;
        expect_idle("R7", "commit while not armed");
        compare_mem("R7", "memory after ignored commits");

        // R11: abandoned command is discarded
        send_cmd(2 * PB + 30, 5, 7, 1'b0);
        send_cmd(2 * PB + 64, 4, 8, 1'b1);
        wait_program("R11 abandon");
        compare_mem("R11", "earlier uncommitted bytes dropped");

        // R9: stimulus during busy is ignored
        send_cmd(3 * PB + 100, 50, 9, 1'b1);
        begin
            int cnt = 0;
            while (busy && cnt < PC + 10) begin
                cnt++;
                cmd_start = (cnt == 5); cmd_addr = AW'(0);
                din_valid = (cnt == 6); din = 8'h00;
                cmd_commit = (cnt == 7);
                @(negedge clk);
            end
            cmd_start = 1'b0; din_valid = 1'b0; cmd_commit = 1'b0;
            check(cnt == PC, "R9", "busy length with stimulus", cnt, PC);
        end
        @(negedge clk); cmd_commit = 1'b1;
        @(negedge clk); cmd_commit = 1'b0;
        expect_idle("R9", "nothing armed after busy");
        compare_mem("R9", "data unaffected by busy stimulus");

        // sweep: every start offset, varying lengths and old contents (R3 R4 R5 R6)
        for (int off = 0; off < PB; off++) begin
            int pg = off % (MEM_N / PB);
            int len = (off * 37) % 200 + 1;
            for (int i = 0; i < PB; i++) begin
                mem[pg * PB + i]     = 8'((i * 7 + off) | 8'h5A);
                ref_mem[pg * PB + i] = 8'((i * 7 + off) | 8'h5A);
            end
            send_cmd(pg * PB + off, len, off + 11, 1'b1);
            wait_program("R3 sweep");
            compare_mem("R4", "sweep page");
        end

        check(bad_access == 0, "R10", "accesses outside busy", bad_access, 0);
        check(bad_order == 0, "R10", "writes not after read", bad_order, 0);
        finished = 1'b1;
        report();
    end

endmodule